// File: doc/BRIEF.md
# CEC Receive Triple-Buffer Manager

This block takes complete frames from a CEC bit-level receiver, delivered as a byte stream framed by a start strobe and an end strobe. It decides whether each frame is addressed to this node and parks accepted frames in one of three independent buffers. Each buffer has its own byte storage, a length register and a ready interrupt line.

Each occupied buffer carries a 2-bit age tag, so software can drain frames oldest-first without timestamps. A buffer is returned by raising its release bit and then dropping it. While the bit is high the buffer is empty and cannot be filled. When an older frame is released, the tags of younger frames close the gap, so the occupied tags always run 1, 2, 3 in arrival order.

Destination filtering compares the low nibble of the header byte against three programmable logical-address slots, each with its own enable. The broadcast address is always accepted. A simple byte-wide register port with a write strobe and a combinational read gives access to the frame bytes, lengths, age status and configuration.

Top module: `cec_rx_tribuf`

## Requirements
- R1: After reset, every age tag is 0, every length register reads 0, all ready interrupts are low, and the control (0x34), mask (0x35) and slot (0x36, 0x37) registers read 0.
- R2: An accepted frame is stored in the lowest-numbered buffer that is empty and available. Its bytes are readable at 0x00+k, 0x10+k or 0x20+k for buffers 0, 1 and 2, and its byte count is readable at 0x30, 0x31 or 0x32. The frame becomes visible in the cycle after its end strobe.
- R3: The status register 0x33 holds the age tag of buffer 0 in bits [1:0], of buffer 1 in bits [3:2] and of buffer 2 in bits [5:4]. A tag reads 0 when its buffer is empty, 1 for the oldest frame, 2 for the next and 3 for the newest of three. A newly stored frame gets a tag equal to the number of occupied buffers including itself.
- R4: Writing 1 to release bit i (bit i of 0x34) empties buffer i, setting its tag and length to 0. Every tag younger than the released one drops by one. The buffer receives no frame until the bit is written back to 0.
- R5: irq_ready[i] is high exactly while buffer i holds a frame.
- R6: A frame longer than 16 bytes keeps its first 16 bytes, and its length reads 16.
- R7: A frame is accepted only when its header's low nibble equals the address of an enabled slot, or equals 15 (broadcast). Slots 0, 1 and 2 are enabled by bits 4, 5 and 6 of 0x35. Slot 0's address is 0x36[3:0], slot 1's is 0x36[7:4] and slot 2's is 0x37[3:0]. A rejected frame changes no buffer.
- R8: A frame that arrives when no buffer is available is discarded, and the stored frames, tags and lengths stay as they were.
- R9: Bit 3 of 0x34 selects multi-buffer mode. With it at 0 only buffer 0 receives frames; with it at 1 all three do. Writing 0x0F releases all buffers at once.
- R10: A frame whose end strobe arrives with no bytes received is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_start | input | 1 | Start-of-frame strobe from the bit receiver |
| rx_byte_vld | input | 1 | A received byte is valid this cycle |
| rx_byte | input | 8 | Received byte, header first |
| rx_end | input | 1 | End-of-frame strobe |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| irq_ready | output | 3 | Per-buffer ready interrupt |

## Verification
The bench releases a middle-aged buffer and then the oldest one. A design that forgets to close the gap leaves duplicate or non-contiguous tags in 0x33. It fills all three buffers and sends a fourth frame, which must leave every tag and length untouched instead of overwriting a buffer. It sends a frame while a release bit is still held, to catch a design that refills a buffer before the handshake completes. It also covers single-buffer mode, each address slot alone, a disabled slot, an overlong frame, and an empty frame that must not take a buffer.

// File: rtl/cec_rxb_pkg.sv
package cec_rxb_pkg;

    localparam int NBUF  = 3;
    localparam int DEPTH = 16;
    localparam int NSLOT = 3;
    localparam int LENW  = $clog2(DEPTH + 1);
    localparam int PTRW  = $clog2(DEPTH);
    localparam int TAGW  = $clog2(NBUF + 1);
    localparam int IDXW  = $clog2(NBUF);

    localparam logic [3:0] BCAST_ADDR = 4'hF;

    localparam logic [7:0] A_LEN0   = 8'h30;
    localparam logic [7:0] A_STATUS = 8'h33;
    localparam logic [7:0] A_CTRL   = 8'h34;
    localparam logic [7:0] A_MASK   = 8'h35;
    localparam logic [7:0] A_SLOT01 = 8'h36;
    localparam logic [7:0] A_SLOT2  = 8'h37;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_FILL,
        RX_SKIP
    } rx_state_e;

    function automatic logic [3:0] dest_nibble(input logic [7:0] hdr);
        return hdr[3:0];
    endfunction

endpackage

// File: rtl/cec_rxb_filter.sv
module cec_rxb_filter
    import cec_rxb_pkg::*;
#(
    parameter int SLOTS = NSLOT
) (
    input  logic [3:0]             dest,
    input  logic [SLOTS-1:0]       slot_en,
    input  logic [SLOTS-1:0][3:0]  slot_addr,
    output logic                   accept
);
    logic [SLOTS-1:0] hit;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign hit[s] = slot_en[s] && (slot_addr[s] == dest);
    end

    assign accept = (|hit) || (dest == BCAST_ADDR);

endmodule

// File: rtl/cec_rxb_store.sv
module cec_rxb_store
    import cec_rxb_pkg::*;
#(
    parameter int D  = DEPTH,
    parameter int PW = PTRW,
    parameter int LW = LENW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_ptr,
    input  logic [7:0]    wr_data,
    input  logic          len_set,
    input  logic [LW-1:0] len_val,
    input  logic          len_clr,
    input  logic [PW-1:0] rd_ptr,
    output logic [7:0]    rd_data,
    output logic [LW-1:0] len_o
);
    logic [7:0]    mem [D];
    logic [LW-1:0] len_q;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst)          len_q <= '0;
        else if (len_clr) len_q <= '0;
        else if (len_set) len_q <= len_val;
    end

    assign rd_data = mem[rd_ptr];
    assign len_o   = len_q;

    // R6: stored length never exceeds the buffer depth
    a_r6_len_cap: assert property (@(posedge clk) disable iff (rst)
        len_q <= LW'(D));

    // R4: a release empties the length in the next cycle
    a_r4_len_cleared: assert property (@(posedge clk) disable iff (rst)
        len_clr |=> len_q == '0);

endmodule

// File: rtl/cec_rxb_order.sv
module cec_rxb_order
    import cec_rxb_pkg::*;
#(
    parameter int NB = NBUF,
    parameter int TW = TAGW,
    parameter int IW = IDXW
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NB-1:0]         rel_req,
    input  logic                  commit,
    input  logic [IW-1:0]         commit_idx,
    output logic [NB-1:0][TW-1:0] tags_o
);
    logic [NB-1:0][TW-1:0] tag_q;
    logic [NB-1:0][TW-1:0] aft;
    logic [NB-1:0][TW-1:0] nxt;
    logic [NB-1:0]         freed;
    logic [TW-1:0]         occ;

    always_comb begin
        for (int i = 0; i < NB; i++) begin
            freed[i] = rel_req[i] && (tag_q[i] != '0);
        end
        for (int i = 0; i < NB; i++) begin
            logic [TW-1:0] sh;
            sh = '0;
            for (int j = 0; j < NB; j++) begin
                if (freed[j] && (tag_q[j] < tag_q[i])) sh = sh + 1'b1;
            end
            if (freed[i] || tag_q[i] == '0) aft[i] = '0;
            else                            aft[i] = tag_q[i] - sh;
        end
        occ = '0;
        for (int i = 0; i < NB; i++) begin
            if (aft[i] != '0) occ = occ + 1'b1;
        end
        nxt = aft;
        if (commit) nxt[commit_idx] = occ + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) tag_q <= '0;
        else     tag_q <= nxt;
    end

    assign tags_o = tag_q;

    // R3: a new frame only lands in an empty buffer
    a_r3_commit_empty: assert property (@(posedge clk) disable iff (rst)
        commit |-> tag_q[commit_idx] == '0);

    for (genvar i = 0; i < NB; i++) begin : g_chk
        // R4: a held release bit leaves the buffer empty next cycle
        a_r4_release_empties: assert property (@(posedge clk) disable iff (rst)
            rel_req[i] |=> tag_q[i] == '0);
        // R3: occupied tags never exceed the buffer count
        a_r3_tag_range: assert property (@(posedge clk) disable iff (rst)
            tag_q[i] <= TW'(NB));
        for (genvar j = i + 1; j < NB; j++) begin : g_pair
            // R3: two occupied buffers never share an age
            a_r3_tags_distinct: assert property (@(posedge clk) disable iff (rst)
                (tag_q[i] != '0) |-> (tag_q[i] != tag_q[j]));
        end
    end

endmodule

// File: rtl/cec_rx_tribuf.sv
module cec_rx_tribuf
    import cec_rxb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_start,
    input  logic        rx_byte_vld,
    input  logic [7:0]  rx_byte,
    input  logic        rx_end,
    input  logic        reg_we,
    input  logic [7:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    output logic [2:0]  irq_ready
);
    // configuration registers
    logic [NBUF-1:0]  clr_q;
    logic             mode_q;
    logic [NSLOT-1:0] mask_q;
    logic [7:0]       slot01_q;
    logic [3:0]       slot2_q;

    // receive path state
    rx_state_e        state_q;
    logic [IDXW-1:0]  tgt_q;
    logic [LENW-1:0]  cnt_q;
    logic [3:0]       dest_q;

    logic [NBUF-1:0][TAGW-1:0] tags;
    logic [NBUF-1:0]           avail;
    logic                      any_avail;
    logic [IDXW-1:0]           first_free;
    logic                      accept;
    logic                      commit;
    logic                      take_byte;
    logic [NSLOT-1:0][3:0]     slot_addr;
    logic [7:0]                rd_data_w [NBUF];
    logic [LENW-1:0]           len_w     [NBUF];

    always_ff @(posedge clk) begin
        if (rst) begin
            clr_q    <= '0;
            mode_q   <= 1'b0;
            mask_q   <= '0;
            slot01_q <= '0;
            slot2_q  <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                A_CTRL: begin
                    clr_q  <= reg_wdata[NBUF-1:0];
                    mode_q <= reg_wdata[3];
                end
                A_MASK:   mask_q   <= reg_wdata[4 +: NSLOT];
                A_SLOT01: slot01_q <= reg_wdata;
                A_SLOT2:  slot2_q  <= reg_wdata[3:0];
                default: ;
            endcase
        end
    end

    assign slot_addr[0] = slot01_q[3:0];
    assign slot_addr[1] = slot01_q[7:4];
    assign slot_addr[2] = slot2_q;

    // buffers open for a new frame
    always_comb begin
        for (int i = 0; i < NBUF; i++) begin
            avail[i] = (tags[i] == '0) && !clr_q[i] && (mode_q || i == 0);
        end
        any_avail  = |avail;
        first_free = '0;
        for (int i = NBUF - 1; i >= 0; i--) begin
            if (avail[i]) first_free = IDXW'(i);
        end
    end

    cec_rxb_filter #(.SLOTS(NSLOT)) u_filter (
        .dest      (dest_q),
        .slot_en   (mask_q),
        .slot_addr (slot_addr),
        .accept    (accept)
    );

    assign take_byte = (state_q == RX_FILL) && rx_byte_vld && !rx_start;
    assign commit    = (state_q == RX_FILL) && rx_end && !rx_start &&
                       (cnt_q != '0) && accept && !clr_q[tgt_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RX_IDLE;
            tgt_q   <= '0;
            cnt_q   <= '0;
            dest_q  <= '0;
        end else if (rx_start) begin
            cnt_q   <= '0;
            tgt_q   <= first_free;
            state_q <= any_avail ? RX_FILL : RX_SKIP;
        end else begin
            if (take_byte && cnt_q < LENW'(DEPTH)) begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == '0) dest_q <= dest_nibble(rx_byte);
            end
            if (rx_end) state_q <= RX_IDLE;
        end
    end

    for (genvar i = 0; i < NBUF; i++) begin : g_buf
        logic sel;
        assign sel = (tgt_q == IDXW'(i));
        cec_rxb_store #(.D(DEPTH), .PW(PTRW), .LW(LENW)) u_store (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (take_byte && sel && cnt_q < LENW'(DEPTH)),
            .wr_ptr  (cnt_q[PTRW-1:0]),
            .wr_data (rx_byte),
            .len_set (commit && sel),
            .len_val (cnt_q),
            .len_clr (clr_q[i]),
            .rd_ptr  (reg_addr[PTRW-1:0]),
            .rd_data (rd_data_w[i]),
            .len_o   (len_w[i])
        );
        assign irq_ready[i] = (tags[i] != '0);
    end

    cec_rxb_order #(.NB(NBUF), .TW(TAGW), .IW(IDXW)) u_order (
        .clk        (clk),
        .rst        (rst),
        .rel_req    (clr_q),
        .commit     (commit),
        .commit_idx (tgt_q),
        .tags_o     (tags)
    );

    // register readback
    always_comb begin
        reg_rdata = '0;
        if (reg_addr < 8'(NBUF * DEPTH)) begin
            for (int i = 0; i < NBUF; i++) begin
                if (reg_addr[7:PTRW] == (8 - PTRW)'(i)) reg_rdata = rd_data_w[i];
            end
        end else begin
            for (int i = 0; i < NBUF; i++) begin
                if (reg_addr == A_LEN0 + 8'(i)) reg_rdata = 8'(len_w[i]);
            end
            case (reg_addr)
                A_STATUS: begin
                    for (int i = 0; i < NBUF; i++) reg_rdata[TAGW*i +: TAGW] = tags[i];
                end
                A_CTRL:   reg_rdata = {4'b0, mode_q, clr_q};
                A_MASK:   reg_rdata = {1'b0, mask_q, 4'b0};
                A_SLOT01: reg_rdata = slot01_q;
                A_SLOT2:  reg_rdata = {4'b0, slot2_q};
                default: ;
            endcase
        end
    end

    // R8: a frame starting with no free buffer is skipped
    a_r8_full_skips: assert property (@(posedge clk) disable iff (rst)
        (rx_start && !any_avail) |=> state_q == RX_SKIP);

    // R10: an empty frame never commits
    a_r10_empty_ignored: assert property (@(posedge clk) disable iff (rst)
        (state_q == RX_FILL && rx_end && cnt_q == '0) |=> $stable(tags));

    // R9: in single-buffer mode buffers 1 and 2 stay empty
    a_r9_single_mode: assert property (@(posedge clk) disable iff (rst)
        (!mode_q && $past(!mode_q) && tags[1] == '0) |=> tags[1] == '0);

endmodule

// File: tb/sim_cec_rx_tribuf.sv
module sim_cec_rx_tribuf;

    logic       clk = 1'b0;
    logic       rst;
    logic       rx_start, rx_byte_vld, rx_end, reg_we;
    logic [7:0] rx_byte, reg_addr, reg_wdata, reg_rdata;
    logic [2:0] irq_ready;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    cec_rx_tribuf u0 (
        .clk(clk), .rst(rst),
        .rx_start(rx_start), .rx_byte_vld(rx_byte_vld), .rx_byte(rx_byte), .rx_end(rx_end),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_ready(irq_ready)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic check_reg(input string req, input logic [7:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic send(input logic [7:0] hdr, input logic [7:0] seed, input int n);
        @(negedge clk);
        rx_start = 1'b1;
        @(negedge clk);
        rx_start = 1'b0;
        for (int k = 0; k < n; k++) begin
            rx_byte_vld = 1'b1;
            rx_byte = (k == 0) ? hdr : seed + 8'(k);
            @(negedge clk);
        end
        rx_byte_vld = 1'b0;
        rx_end = 1'b1;
        @(negedge clk);
        rx_end = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        check_reg("R1 status", 8'h33, 8'h00);
        check_reg("R1 len0", 8'h30, 8'h00);
        check_reg("R1 len2", 8'h32, 8'h00);
        check_reg("R1 ctrl", 8'h34, 8'h00);
        check_reg("R1 mask", 8'h35, 8'h00);
        check_reg("R1 slot", 8'h36, 8'h00);
        check("R1 irq", {5'b0, irq_ready}, 8'h00);
    endtask

    task automatic t_single_mode;
        wr(8'h35, 8'h10);
        wr(8'h36, 8'h04);
        send(8'h04, 8'hA0, 2);
        check_reg("R2 len0", 8'h30, 8'h02);
        check_reg("R2 byte1", 8'h01, 8'hA1);
        check_reg("R3 status one", 8'h33, 8'h01);
        check("R5 irq one", {5'b0, irq_ready}, 8'h01);
        send(8'h0F, 8'hB0, 3);
        check_reg("R9 single mode drops", 8'h33, 8'h01);
        check_reg("R9 len1 unused", 8'h31, 8'h00);
        wr(8'h34, 8'h01);
        check_reg("R4 status released", 8'h33, 8'h00);
        check_reg("R4 len released", 8'h30, 8'h00);
        check("R5 irq released", {5'b0, irq_ready}, 8'h00);
        wr(8'h34, 8'h00);
    endtask

    task automatic t_fill_all;
        wr(8'h34, 8'h08);
        send(8'h04, 8'h10, 3);
        send(8'h0F, 8'h20, 3);
        send(8'h14, 8'h30, 4);
        check_reg("R3 three tags", 8'h33, 8'h39);
        check("R5 irq all", {5'b0, irq_ready}, 8'h07);
        check_reg("R2 buf1 hdr", 8'h10, 8'h0F);
        check_reg("R2 buf1 byte2", 8'h12, 8'h22);
        check_reg("R2 len1", 8'h31, 8'h03);
        check_reg("R2 len2", 8'h32, 8'h04);
        send(8'h0F, 8'h50, 2);
        check_reg("R8 full status", 8'h33, 8'h39);
        check_reg("R8 full len0", 8'h30, 8'h03);
        check_reg("R8 full data", 8'h11, 8'h21);
    endtask

    task automatic t_release_order;
        wr(8'h34, 8'h0A);
        check_reg("R4 middle release", 8'h33, 8'h21);
        send(8'h0F, 8'h60, 2);
        check_reg("R4 held bit blocks", 8'h33, 8'h21);
        wr(8'h34, 8'h08);
        send(8'h0F, 8'h70, 2);
        check_reg("R2 refill buf1", 8'h33, 8'h2D);
        check_reg("R2 refill byte", 8'h11, 8'h71);
        wr(8'h34, 8'h09);
        check_reg("R4 oldest release", 8'h33, 8'h18);
        check("R5 irq after", {5'b0, irq_ready}, 8'h06);
        wr(8'h34, 8'h08);
    endtask

    task automatic t_filter;
        wr(8'h34, 8'h0F);
        check_reg("R9 release all", 8'h33, 8'h00);
        wr(8'h34, 8'h08);
        send(8'h05, 8'h80, 2);
        check_reg("R7 reject", 8'h33, 8'h00);
        wr(8'h35, 8'h30);
        wr(8'h36, 8'h54);
        send(8'h35, 8'h80, 2);
        check_reg("R7 slot1", 8'h33, 8'h01);
        wr(8'h35, 8'h70);
        wr(8'h37, 8'h09);
        send(8'h09, 8'h90, 2);
        check_reg("R7 slot2", 8'h33, 8'h09);
        wr(8'h35, 8'h60);
        send(8'h04, 8'h90, 2);
        check_reg("R7 disabled slot0", 8'h33, 8'h09);
    endtask

    task automatic t_long_and_empty;
        send(8'h0F, 8'h40, 20);
        check_reg("R6 len cap", 8'h32, 8'h10);
        check_reg("R6 last byte", 8'h2F, 8'h4F);
        check_reg("R6 status", 8'h33, 8'h39);
        wr(8'h34, 8'h0F);
        wr(8'h34, 8'h08);
        send(8'h0F, 8'h00, 0);
        check_reg("R10 empty frame", 8'h33, 8'h00);
        check_reg("R10 len0", 8'h30, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        rx_start = 1'b0; rx_byte_vld = 1'b0; rx_byte = '0; rx_end = 1'b0;
        reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_single_mode;
        t_fill_all;
        t_release_order;
        t_filter;
        t_long_and_empty;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule